// File: doc/BRIEF.md
# Accumulator Shift and Bit-Test Execution Unit

This block executes one inherent-mode operation per clock for a small 8-bit machine with two accumulators. The high accumulator and the low accumulator together also form one double-width register (high half on top). On each cycle where `issue` is high, the unit takes an opcode, the present accumulator values, the present condition-code byte and an immediate operand. One clock later it presents the new accumulators, the new condition-code byte and a `done` strobe.

The supported work is a left arithmetic shift of either accumulator or of the joined pair, a right arithmetic shift of either accumulator, and a non-destructive AND test of either accumulator against the operand. Any other opcode passes every value through unchanged and raises `illegal` for that one result cycle. The caller keeps the register file and writes back what the unit returns.

The condition-code byte uses bit 0 = C (carry), bit 1 = V (overflow), bit 2 = Z (zero), bit 3 = N (negative). Bits 7:4 are owned by other logic and are never altered here.

Top module: `acc_shift_bittest`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes to zero on that edge: `a_out`, `b_out`, `ccr_out`, `done` and `illegal`.
- R2: Opcode 0x48 shifts the high accumulator left and opcode 0x58 shifts the low accumulator left. A 0 enters bit 0, the old bit 7 goes to C, and the other accumulator is returned unchanged.
- R3: Opcode 0x59 shifts the 16-bit pair {high, low} left by one. The low accumulator's old bit 7 enters the high accumulator's bit 0, the high accumulator's old bit 7 goes to C, and 0 enters the low accumulator's bit 0.
- R4: Opcode 0x47 shifts the high accumulator right arithmetically and opcode 0x57 does the same to the low accumulator. Bit 7 keeps its value, the old bit 0 goes to C, and the other accumulator is returned unchanged.
- R5: After a shift, N equals the result's top bit (bit 15 for opcode 0x59, bit 7 otherwise). Z is 1 exactly when the whole result, all 16 bits for 0x59, is zero.
- R6: After a shift, V equals the new N XOR the new C.
- R7: Opcode 0x85 (high accumulator) and opcode 0xC5 (low accumulator) AND the accumulator with `operand`. N takes the AND's bit 7 and Z is 1 when the AND is zero. V is cleared, C is kept, and both accumulators are returned unchanged.
- R8: Condition-code bits 7:4 of every result equal those bits of `ccr_in` at the issuing edge.
- R9: An issued opcode outside the seven above returns `a_in`, `b_in` and `ccr_in` unchanged and raises `illegal` together with `done` for exactly that result cycle.
- R10: Results appear on the edge that samples `issue` high, with `done` high. When `issue` is low at an edge, `done` and `illegal` go low and `a_out`, `b_out` and `ccr_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation valid this cycle |
| opcode | input | 8 | Inherent-mode opcode |
| a_in | input | 8 | Current high accumulator |
| b_in | input | 8 | Current low accumulator |
| ccr_in | input | 8 | Current condition-code byte |
| operand | input | 8 | Immediate operand for bit test |
| a_out | output | 8 | Updated high accumulator |
| b_out | output | 8 | Updated low accumulator |
| ccr_out | output | 8 | Updated condition-code byte |
| done | output | 1 | Result valid |
| illegal | output | 1 | Issued opcode was unsupported |

## Verification
The bench builds the unit with its default 8-bit accumulator width. At that width the whole high-accumulator range can be swept against every supported opcode. The low accumulator is paired with the edge values 0x00, 0x01, 0x7F, 0x80, 0xFF and 0x5A. As a result, every carry into and out of the A/B boundary of the double shift is reached, along with every sign and zero case. All 256 opcode values are then issued once, which separates each unsupported code from the seven accepted ones.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

    localparam int OPC_W  = 8;
    localparam int CCR_W  = 8;

    localparam int FLG_C  = 0;
    localparam int FLG_V  = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_N  = 3;
    localparam int FLG_LO = 4;

    localparam logic [OPC_W-1:0] OPC_SHL_HI  = 8'h48;
    localparam logic [OPC_W-1:0] OPC_SHL_LO  = 8'h58;
    localparam logic [OPC_W-1:0] OPC_SHL_DBL = 8'h59;
    localparam logic [OPC_W-1:0] OPC_SHR_HI  = 8'h47;
    localparam logic [OPC_W-1:0] OPC_SHR_LO  = 8'h57;
    localparam logic [OPC_W-1:0] OPC_TST_HI  = 8'h85;
    localparam logic [OPC_W-1:0] OPC_TST_LO  = 8'hC5;

    typedef enum logic [2:0] {
        K_NONE,
        K_SHL_HI,
        K_SHL_LO,
        K_SHL_DBL,
        K_SHR_HI,
        K_SHR_LO,
        K_TST_HI,
        K_TST_LO
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic op_kind_e classify(input logic [OPC_W-1:0] opc);
        op_kind_e k;
        case (opc)
            OPC_SHL_HI:  k = K_SHL_HI;
            OPC_SHL_LO:  k = K_SHL_LO;
            OPC_SHL_DBL: k = K_SHL_DBL;
            OPC_SHR_HI:  k = K_SHR_HI;
            OPC_SHR_LO:  k = K_SHR_LO;
            OPC_TST_HI:  k = K_TST_HI;
            OPC_TST_LO:  k = K_TST_LO;
            default:     k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic is_shift(input op_kind_e k);
        return (k == K_SHL_HI) || (k == K_SHL_LO) || (k == K_SHL_DBL) ||
               (k == K_SHR_HI) || (k == K_SHR_LO);
    endfunction

    function automatic flags_t unpack_flags(input logic [CCR_W-1:0] ccr);
        flags_t f;
        f.n = ccr[FLG_N];
        f.z = ccr[FLG_Z];
        f.v = ccr[FLG_V];
        f.c = ccr[FLG_C];
        return f;
    endfunction

endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
    import acc_shift_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_kind_e         kind,
    output logic             legal,
    output logic             shift_op
);
    always_comb begin
        kind     = classify(opcode);
        legal    = (kind != K_NONE);
        shift_op = is_shift(kind);
    end
endmodule

// File: rtl/acc_shift_shifter.sv
module acc_shift_shifter #(
    parameter int W    = 8,
    parameter bit LEFT = 1'b1
) (
    input  logic [W-1:0] din,
    input  logic         fill,
    output logic [W-1:0] dout,
    output logic         cout
);
    generate
        if (LEFT) begin : g_left
            always_comb begin
                dout = {din[W-2:0], fill};
                cout = din[W-1];
            end
        end else begin : g_right
            logic unused_fill;
            always_comb begin
                dout        = {din[W-1], din[W-1:1]};
                cout        = din[0];
                unused_fill = fill;
            end
        end
    endgenerate
endmodule

// File: rtl/acc_shift_alu.sv
module acc_shift_alu
    import acc_shift_pkg::*;
#(
    parameter int W = 8
) (
    input  op_kind_e     kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] operand,
    input  flags_t       f_in,
    output logic [W-1:0] a_res,
    output logic [W-1:0] b_res,
    output flags_t       f_res
);
    localparam int DW = 2 * W;

    logic [W-1:0] shl_a, shl_b, shr_a, shr_b;
    logic         shl_a_c, shl_b_c, shr_a_c, shr_b_c;
    logic         hi_fill;
    logic [W-1:0] tst_src, tst_and;
    logic [DW-1:0] dbl;

    assign hi_fill = (kind == K_SHL_DBL) ? b[W-1] : 1'b0;

    acc_shift_shifter #(.W(W), .LEFT(1'b1)) u_shl_a (
        .din(a), .fill(hi_fill), .dout(shl_a), .cout(shl_a_c));
    acc_shift_shifter #(.W(W), .LEFT(1'b1)) u_shl_b (
        .din(b), .fill(1'b0), .dout(shl_b), .cout(shl_b_c));
    acc_shift_shifter #(.W(W), .LEFT(1'b0)) u_shr_a (
        .din(a), .fill(1'b0), .dout(shr_a), .cout(shr_a_c));
    acc_shift_shifter #(.W(W), .LEFT(1'b0)) u_shr_b (
        .din(b), .fill(1'b0), .dout(shr_b), .cout(shr_b_c));

    assign tst_src = (kind == K_TST_LO) ? b : a;
    assign tst_and = tst_src & operand;

    always_comb begin
        a_res = a;
        b_res = b;
        f_res = f_in;
        dbl   = '0;
        case (kind)
            K_SHL_HI: begin
                a_res   = shl_a;
                f_res.c = shl_a_c;
                f_res.n = shl_a[W-1];
                f_res.z = (shl_a == '0);
            end
            K_SHL_LO: begin
                b_res   = shl_b;
                f_res.c = shl_b_c;
                f_res.n = shl_b[W-1];
                f_res.z = (shl_b == '0);
            end
            K_SHL_DBL: begin
                a_res   = shl_a;
                b_res   = shl_b;
                dbl     = {shl_a, shl_b};
                f_res.c = shl_a_c;
                f_res.n = dbl[DW-1];
                f_res.z = (dbl == '0);
            end
            K_SHR_HI: begin
                a_res   = shr_a;
                f_res.c = shr_a_c;
                f_res.n = shr_a[W-1];
                f_res.z = (shr_a == '0);
            end
            K_SHR_LO: begin
                b_res   = shr_b;
                f_res.c = shr_b_c;
                f_res.n = shr_b[W-1];
                f_res.z = (shr_b == '0);
            end
            K_TST_HI, K_TST_LO: begin
                f_res.n = tst_and[W-1];
                f_res.z = (tst_and == '0);
                f_res.v = 1'b0;
            end
            default: ;
        endcase
        if (is_shift(kind)) begin
            f_res.v = f_res.n ^ f_res.c;
        end
    end
endmodule

// File: rtl/acc_shift_bittest.sv
module acc_shift_bittest
    import acc_shift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_in,
    input  logic [CCR_W-1:0] ccr_in,
    input  logic [W-1:0]     operand,
    output logic [W-1:0]     a_out,
    output logic [W-1:0]     b_out,
    output logic [CCR_W-1:0] ccr_out,
    output logic             done,
    output logic             illegal
);
    op_kind_e     kind;
    logic         legal, shift_op;
    logic [W-1:0] a_res, b_res;
    flags_t       f_res;
    logic [CCR_W-1:0] ccr_next;

    op_kind_e     kind_q;
    logic         shift_q;

    acc_shift_decode u_decode (
        .opcode(opcode), .kind(kind), .legal(legal), .shift_op(shift_op));

    acc_shift_alu #(.W(W)) u_alu (
        .kind(kind), .a(a_in), .b(b_in), .operand(operand),
        .f_in(unpack_flags(ccr_in)),
        .a_res(a_res), .b_res(b_res), .f_res(f_res));

    always_comb begin
        ccr_next = ccr_in;
        if (legal) begin
            ccr_next[FLG_N] = f_res.n;
            ccr_next[FLG_Z] = f_res.z;
            ccr_next[FLG_V] = f_res.v;
            ccr_next[FLG_C] = f_res.c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_out   <= '0;
            b_out   <= '0;
            ccr_out <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
            kind_q  <= K_NONE;
            shift_q <= 1'b0;
        end else begin
            done    <= issue;
            illegal <= issue && !legal;
            if (issue) begin
                a_out   <= a_res;
                b_out   <= b_res;
                ccr_out <= ccr_next;
                kind_q  <= kind;
                shift_q <= shift_op;
            end
        end
    end

    // R6: overflow flag of every completed shift is N xor C
    assert_shift_v_R6: assert property (@(posedge clk) disable iff (rst)
        (done && shift_q) |-> (ccr_out[FLG_V] == (ccr_out[FLG_N] ^ ccr_out[FLG_C])));

    // R7: a bit test writes neither accumulator, clears V, keeps C
    assert_bittest_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (done && (kind_q == K_TST_HI || kind_q == K_TST_LO)) |->
        (a_out == $past(a_in) && b_out == $past(b_in) &&
         !ccr_out[FLG_V] && ccr_out[FLG_C] == $past(ccr_in[FLG_C])));

    // R8: upper condition-code bits pass through
    assert_upper_ccr_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (ccr_out[CCR_W-1:FLG_LO] == $past(ccr_in[CCR_W-1:FLG_LO])));

    // R9: an unsupported opcode changes nothing and is flagged with done
    assert_illegal_pass_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && a_out == $past(a_in) && b_out == $past(b_in) &&
                     ccr_out == $past(ccr_in)));

    // R10: an idle cycle holds results and drops the strobes
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !issue |=> (!done && !illegal && $stable(a_out) && $stable(b_out) &&
                    $stable(ccr_out)));

    // R3: double shift carries the low half's top bit into the high half
    assert_dbl_link_R3: assert property (@(posedge clk) disable iff (rst)
        (done && kind_q == K_SHL_DBL) |->
        (a_out[0] == $past(b_in[W-1]) && ccr_out[FLG_C] == $past(a_in[W-1])));
endmodule

// File: tb/acc_shift_bittest_bench.sv
module acc_shift_bittest_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       issue;
    logic [7:0] opcode, a_in, b_in, ccr_in, operand;
    logic [7:0] a_out, b_out, ccr_out;
    logic       done, illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    acc_shift_bittest u_acc_shift_bittest (
        .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
        .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in), .operand(operand),
        .a_out(a_out), .b_out(b_out), .ccr_out(ccr_out),
        .done(done), .illegal(illegal));

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h48, 8'h58: return "R2";
            8'h59:        return "R3";
            8'h47, 8'h57: return "R4";
            8'h85, 8'hC5: return "R7";
            default:      return "R9";
        endcase
    endfunction

    // independent reference: returns {a, b, ccr, illegal}
    function automatic logic [24:0] model(input logic [7:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] c,
                                          input logic [7:0] opd);
        int ra = a, rb = b, n = 0, z = 0, v = c[1], cy = c[0], ill = 0;
        int full;
        case (op)
            8'h48: begin cy = a / 128; ra = (a * 2) % 256; n = ra / 128; z = (ra == 0); end
            8'h58: begin cy = b / 128; rb = (b * 2) % 256; n = rb / 128; z = (rb == 0); end
            8'h59: begin
                full = (a * 256 + b) * 2;
                cy = full / 65536; full = full % 65536;
                ra = full / 256; rb = full % 256;
                n = full / 32768; z = (full == 0);
            end
            8'h47: begin cy = a % 2; ra = a / 2 + (a / 128) * 128; n = ra / 128; z = (ra == 0); end
            8'h57: begin cy = b % 2; rb = b / 2 + (b / 128) * 128; n = rb / 128; z = (rb == 0); end
            8'h85: begin n = (a & opd) / 128; z = ((a & opd) == 0); v = 0; end
            8'hC5: begin n = (b & opd) / 128; z = ((b & opd) == 0); v = 0; end
            default: ill = 1;
        endcase
        if (op inside {8'h48, 8'h58, 8'h59, 8'h47, 8'h57}) begin
            v = n ^ cy;   // R5 N/Z above, R6 overflow here
        end
        if (ill) return {a, b, c, 1'b1};
        return {ra[7:0], rb[7:0], c[7:4], n[0], z[0], v[0], cy[0], 1'b0};
    endfunction

    task automatic check(input string tag, input logic [24:0] exp, input logic exp_done);
        n_checks++;
        if ({a_out, b_out, ccr_out, illegal} !== exp || done !== exp_done) begin
            n_fail++;
            $display("FAIL %s: got a=%h b=%h ccr=%h ill=%b done=%b, expected a=%h b=%h ccr=%h ill=%b done=%b",
                     tag, a_out, b_out, ccr_out, illegal, done,
                     exp[24:17], exp[16:9], exp[8:1], exp[0], exp_done);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input logic [7:0] opd);
        issue = 1'b1; opcode = op; a_in = a; b_in = b; ccr_in = c; operand = opd;
        @(negedge clk);
        check(tag_of(op), model(op, a, b, c, opd), 1'b1);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] ops [7] = '{8'h48, 8'h58, 8'h59, 8'h47, 8'h57, 8'h85, 8'hC5};
        logic [7:0] bset [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
        logic [24:0] hold;

        rst = 1'b1; issue = 1'b0; opcode = '0; a_in = 8'hAA; b_in = 8'h55;
        ccr_in = 8'hFF; operand = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset clears every output
        check("R1", 25'd0, 1'b0);
        rst = 1'b0;

        // R10: an idle edge keeps zeros and no strobe
        @(negedge clk);
        check("R10", 25'd0, 1'b0);

        // corner values for each opcode (R2 R3 R4 R5 R6 R7 R8)
        foreach (ops[i]) begin
            run_op(ops[i], 8'h00, 8'h00, 8'h00, 8'h00);
            run_op(ops[i], 8'h80, 8'h80, 8'hF0, 8'h80);
            run_op(ops[i], 8'hFF, 8'hFF, 8'h0F, 8'h7F);
            run_op(ops[i], 8'h7F, 8'h7F, 8'hA5, 8'h80);
        end

        // sweep: every A value, edge B values, varied flags and operand
        foreach (ops[i]) begin
            for (int a = 0; a < 256; a++) begin
                foreach (bset[j]) begin
                    run_op(ops[i], a[7:0], bset[j], a[7:0] ^ bset[j] ^ 8'hC3,
                           {bset[j][3:0], a[7:4]} ^ 8'h3C);
                end
            end
        end

        // R9: every opcode value, supported ones checked alongside
        for (int op = 0; op < 256; op++) begin
            run_op(op[7:0], 8'h96, 8'h69, op[7:0] ^ 8'h5A, 8'hF0);
        end

        // R10: idle cycles hold the last result
        run_op(8'h59, 8'hC0, 8'h81, 8'h20, 8'h00);
        hold = model(8'h59, 8'hC0, 8'h81, 8'h20, 8'h00);
        issue = 1'b0; opcode = 8'h48; a_in = 8'h01;
        @(negedge clk);
        check("R10", hold, 1'b0);
        @(negedge clk);
        check("R10", hold, 1'b0);

        // R9: pulse lasts one result cycle only
        run_op(8'h12, 8'h01, 8'h02, 8'h03, 8'h04);
        issue = 1'b0;
        @(negedge clk);
        check("R9", {8'h01, 8'h02, 8'h03, 1'b0}, 1'b0);

        // R1: reset mid-run clears results
        rst = 1'b1;
        @(negedge clk);
        check("R1", 25'd0, 1'b0);
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule